// File: doc/BRIEF.md
# Serial I/Q Burst Deframer

This block turns a one-bit serial receive line into parallel in-phase and quadrature samples. A level-type enable accompanies the line. The cycle in which the enable is first seen high carries bit 0 of the first frame. After that, the enable simply stays high for the whole burst, and the block counts out fixed 96-bit frames back to back without looking for any further marker.

Each frame begins with its sample bits and ends with padding. In single-rate mode there is one 16-bit I word and one 16-bit Q word, and the rest of the frame is padding. In double-rate mode there are two such pairs before the padding. Sample bits are collected most significant bit first into signed two's-complement words. Padding is discarded. Every complete pair is presented with a one-cycle strobe. A saturating counter tracks how many pairs the current burst has delivered. When the enable drops, the block goes idle and loses any pair that was only partly received.

Top module: `serial_iq_deframer`

## Requirements
- R1: While reset is held and in the first cycle after it, `iqValid` is 0, `pairCount` is 0, and `iSample` and `qSample` are 0.
- R2: The cycle in which `frameEn` is sampled high after being low carries frame bit 0. While `frameEn` stays high, frames of 96 bits follow back to back with no re-alignment.
- R3: With `dualRate`=0 at burst start, frame bits 0..15 form I and bits 16..31 form Q, each sent MSB first and output as a signed 16-bit value. Bits 32..95 are padding.
- R4: With `dualRate`=1 at burst start, frame bits 0..15 / 16..31 form the first I/Q pair and bits 32..47 / 48..63 the second pair, each MSB first. Bits 64..95 are padding.
- R5: Padding bits never reach the outputs, and `iqValid` never rises for anything other than a complete pair, including while `frameEn` is low.
- R6: `dualRate` is taken only in the cycle that starts a burst. Changing it during the burst has no effect on decoding.
- R7: `iqValid` is high for exactly one cycle, the cycle after the last Q bit is sampled. I and Q of one pair appear together in that cycle and hold their values until the next pulse.
- R8: When `frameEn` falls, the block goes idle. An I/Q pair not fully received is never output, and the next rising edge re-aligns from bit 0.
- R9: `pairCount` rises by one in the same cycle as each `iqValid` pulse. It becomes 0 in the cycle after a burst-starting edge and saturates at its all-ones maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| serBit | input | 1 | Serial receive data |
| frameEn | input | 1 | Burst enable, high for the whole burst |
| dualRate | input | 1 | 1 selects two I/Q pairs per frame, sampled at burst start |
| iqValid | output | 1 | One-cycle strobe for a new pair |
| iSample | output | SampleWidth | Signed in-phase word |
| qSample | output | SampleWidth | Signed quadrature word |
| pairCount | output | CountWidth | Saturating pairs-per-burst count |

## Verification
The bound checker watches several rules on every cycle: the strobe lasts one cycle, the sample outputs hold between strobes, nothing is strobed during idle, the counter steps only with a strobe and clears after a rising enable, and it stays at its maximum once saturated. Bit alignment, MSB-first packing, padding removal in both modes, the mode being taken only at burst start, and the loss of a cut-off pair all depend on the data pattern. Only the bench's scenarios can show those, by comparing every decoded pair and its arrival cycle against words it built itself.

// File: rtl/iq_deframer_pkg.sv
package iq_deframer_pkg;

  // Per-bit strobes issued by the frame control to the word datapath.
  typedef struct packed {
    logic shiftEn;     // current serial bit belongs to a sample word
    logic latchI;      // current bit completes an I word
    logic emitPair;    // current bit completes a Q word, so a pair is ready
    logic clearCount;  // a new burst starts in this cycle
  } deframeStrobe_t;

endpackage

// File: rtl/iq_frame_ctrl.sv
module iq_frame_ctrl
  import iq_deframer_pkg::*;
#(
  parameter int SampleWidth = 16,
  parameter int FrameBits   = 96
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           frameEn,
  input  logic           dualRate,
  output deframeStrobe_t strb
);

  localparam int PosW = $clog2(FrameBits);
  localparam logic [PosW-1:0] LastPos     = PosW'(FrameBits - 1);
  localparam logic [PosW-1:0] WordLen     = PosW'(SampleWidth);
  localparam logic [PosW-1:0] WordLastBit = PosW'(SampleWidth - 1);
  localparam logic [PosW-1:0] SingleLimit = PosW'(2 * SampleWidth);
  localparam logic [PosW-1:0] DualLimit   = PosW'(4 * SampleWidth);

  logic            enPrev;
  logic            dualLatched;
  logic [PosW-1:0] bitPos;

  logic            burstRise;
  logic [PosW-1:0] posNow;
  logic            modeNow;
  logic [PosW-1:0] sampleLimit;
  logic [PosW-1:0] posInWord;
  logic [PosW-1:0] wordIndex;
  logic            inSample;
  logic            wordEnd;

  // A burst starts in the very cycle the enable is first seen high; that
  // cycle is treated as frame position zero without waiting for a register.
  always_comb begin
    burstRise   = frameEn & ~enPrev;
    posNow      = burstRise ? '0 : bitPos;
    modeNow     = burstRise ? dualRate : dualLatched;
    sampleLimit = modeNow ? DualLimit : SingleLimit;
    posInWord   = posNow % WordLen;
    wordIndex   = posNow / WordLen;
    inSample    = frameEn && (posNow < sampleLimit);
    wordEnd     = inSample && (posInWord == WordLastBit);
  end

  always_comb begin
    strb.shiftEn    = inSample;
    strb.latchI     = wordEnd & ~wordIndex[0];
    strb.emitPair   = wordEnd & wordIndex[0];
    strb.clearCount = burstRise;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev      <= 1'b0;
      dualLatched <= 1'b0;
      bitPos      <= '0;
    end else begin
      enPrev <= frameEn;
      if (burstRise) dualLatched <= dualRate;
      if (!frameEn) begin
        bitPos <= '0;
      end else if (posNow == LastPos) begin
        bitPos <= '0;
      end else begin
        bitPos <= posNow + 1'b1;
      end
    end
  end

endmodule

// File: rtl/iq_word_path.sv
module iq_word_path
  import iq_deframer_pkg::*;
#(
  parameter int SampleWidth = 16,
  parameter int CountWidth  = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          serBit,
  input  deframeStrobe_t                strb,
  output logic                          iqValid,
  output logic signed [SampleWidth-1:0] iSample,
  output logic signed [SampleWidth-1:0] qSample,
  output logic        [CountWidth-1:0]  pairCount
);

  localparam logic [CountWidth-1:0] CountMax = '1;

  // Only SampleWidth-1 bits of history are kept; the newest bit comes
  // straight from the line when a word completes.
  logic        [SampleWidth-2:0] history;
  logic        [SampleWidth-1:0] nextWord;
  logic        [SampleWidth-1:0] iHold;
  logic signed [SampleWidth-1:0] iOut;
  logic signed [SampleWidth-1:0] qOut;
  logic                          validQ;
  logic        [CountWidth-1:0]  count;

  always_comb nextWord = {history, serBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      history <= '0;
      iHold   <= '0;
      iOut    <= '0;
      qOut    <= '0;
      validQ  <= 1'b0;
      count   <= '0;
    end else begin
      if (strb.shiftEn) history <= nextWord[SampleWidth-2:0];
      if (strb.latchI)  iHold   <= nextWord;
      validQ <= strb.emitPair;
      if (strb.emitPair) begin
        iOut <= iHold;
        qOut <= nextWord;
      end
      if (strb.clearCount) begin
        count <= '0;
      end else if (strb.emitPair && (count != CountMax)) begin
        count <= count + 1'b1;
      end
    end
  end

  assign iqValid   = validQ;
  assign iSample   = iOut;
  assign qSample   = qOut;
  assign pairCount = count;

endmodule

// File: rtl/serial_iq_deframer.sv
module serial_iq_deframer
  import iq_deframer_pkg::*;
#(
  parameter int SampleWidth = 16,
  parameter int FrameBits   = 96,
  parameter int CountWidth  = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          serBit,
  input  logic                          frameEn,
  input  logic                          dualRate,
  output logic                          iqValid,
  output logic signed [SampleWidth-1:0] iSample,
  output logic signed [SampleWidth-1:0] qSample,
  output logic        [CountWidth-1:0]  pairCount
);

  deframeStrobe_t strb;

  iq_frame_ctrl #(
    .SampleWidth(SampleWidth),
    .FrameBits  (FrameBits)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .frameEn (frameEn),
    .dualRate(dualRate),
    .strb    (strb)
  );

  iq_word_path #(
    .SampleWidth(SampleWidth),
    .CountWidth (CountWidth)
  ) path_i (
    .clk      (clk),
    .rstN     (rstN),
    .serBit   (serBit),
    .strb     (strb),
    .iqValid  (iqValid),
    .iSample  (iSample),
    .qSample  (qSample),
    .pairCount(pairCount)
  );

endmodule

// File: rtl/iq_deframer_chk.sv
module iq_deframer_chk #(
  parameter int SampleWidth = 16,
  parameter int CountWidth  = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   frameEn,
  input logic                   iqValid,
  input logic [SampleWidth-1:0] iSample,
  input logic [SampleWidth-1:0] qSample,
  input logic [CountWidth-1:0]  pairCount
);

  localparam logic [CountWidth-1:0] CountMax = '1;

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    iqValid |=> !iqValid);

  // R7
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !iqValid |-> ($stable(iSample) && $stable(qSample)));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!frameEn && !$past(frameEn)) |-> !iqValid);

  // R9
  count_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameEn) |=> (pairCount == '0));

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (iqValid && ($past(pairCount) != CountMax))
      |-> (pairCount == CountWidth'($past(pairCount) + 1'b1)));

  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!iqValid && !($past(frameEn) && !$past(frameEn, 2)))
      |-> (pairCount == $past(pairCount)));

  // R9
  count_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pairCount == CountMax && !frameEn) |=> (pairCount == CountMax));

endmodule

bind serial_iq_deframer iq_deframer_chk #(
  .SampleWidth(SampleWidth),
  .CountWidth (CountWidth)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .frameEn  (frameEn),
  .iqValid  (iqValid),
  .iSample  (iSample),
  .qSample  (qSample),
  .pairCount(pairCount)
);

// File: tb/serial_iq_deframer_tb_top.sv
`timescale 1ns/1ps
module serial_iq_deframer_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serBit = 1'b0;
  logic frameEn = 1'b0;
  logic dualRate = 1'b0;

  logic               iqValid;
  logic signed [15:0] iSample;
  logic signed [15:0] qSample;
  logic        [15:0] pairCount;
  logic               satValid;
  logic signed [15:0] satI;
  logic signed [15:0] satQ;
  logic        [1:0]  satCount;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string curReq = "R3";
  logic [63:0] expQ[$];   // {push cycle, I, Q}

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  serial_iq_deframer dut_i (
    .clk(clk), .rstN(rstN), .serBit(serBit), .frameEn(frameEn), .dualRate(dualRate),
    .iqValid(iqValid), .iSample(iSample), .qSample(qSample), .pairCount(pairCount));

  serial_iq_deframer #(.CountWidth(2)) satDut_i (
    .clk(clk), .rstN(rstN), .serBit(serBit), .frameEn(frameEn), .dualRate(dualRate),
    .iqValid(satValid), .iSample(satI), .qSample(satQ), .pairCount(satCount));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // Driver: sends a burst of whole frames; cut >= 0 drops the enable
  // before bit number cut of the burst.
  task automatic sendBurst(input int pairs, input bit dual, input bit flip, input int cut);
    logic [15:0] w [4];
    int perFrame;
    int sent;
    int done;
    int slot;
    bit stop;
    perFrame = dual ? 2 : 1;
    sent = 0;
    done = 0;
    stop = 0;
    @(negedge clk);
    dualRate = dual;
    while (!stop && done < pairs) begin
      for (int k = 0; k < 4; k++) w[k] = 16'($urandom);
      for (int p = 0; p < 96; p++) begin
        if (cut >= 0 && sent == cut) begin
          stop = 1;
          break;
        end
        if (sent != 0) @(negedge clk);
        frameEn = 1'b1;
        slot = p / 16;
        if (p < perFrame * 32) serBit = w[slot][15 - (p % 16)];
        else serBit = 1'($urandom);
        if (p < perFrame * 32 && (p % 32) == 31) expQ.push_back({32'(cyc), w[slot-1], w[slot]});
        if (flip && sent == 5) dualRate = ~dual;
        sent++;
      end
      if (!stop) done += perFrame;
    end
    @(negedge clk);
    frameEn = 1'b0;
    serBit = 1'($urandom);
  endtask

  // Monitor: every strobe must match the oldest expected pair, one cycle
  // after its last Q bit was driven (R7).
  initial begin
    logic [63:0] e;
    forever begin
      @(negedge clk);
      if (rstN && iqValid) begin
        if (expQ.size() == 0) begin
          check(0, "R5 R8 unexpected pair", {32'd0, iSample, qSample}, 64'd0);
        end else begin
          e = expQ.pop_front();
          check({iSample, qSample} == e[31:0], curReq, {32'd0, iSample, qSample}, {32'd0, e[31:0]});
          check(cyc == int'(e[63:32]) + 1, "R7 strobe cycle", 64'(cyc), 64'(e[63:32] + 1));
        end
      end
    end
  end

  task automatic checkCount(input int expCnt, input string req);
    int satExp;
    satExp = (expCnt > 3) ? 3 : expCnt;
    @(negedge clk);
    check(pairCount == 16'(expCnt), req, 64'(pairCount), 64'(expCnt));
    check(satCount == 2'(satExp), {req, " saturation R9"}, 64'(satCount), 64'(satExp));
    check(expQ.size() == 0, "R5 queue drained", 64'(expQ.size()), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(iqValid == 1'b0 && pairCount == 16'd0, "R1 in reset", {iqValid, 15'd0, pairCount}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(iqValid == 1'b0 && pairCount == 16'd0 && iSample == 16'sd0 && qSample == 16'sd0,
          "R1 after reset", {iqValid, 15'd0, pairCount, iSample}, 64'd0);

    // R3 and R2: single-rate burst, enable held through many frames
    curReq = "R3 single-rate pair";
    sendBurst(6, 1'b0, 1'b0, -1);
    checkCount(6, "R9 count single");

    // R2: long burst, no re-alignment while enable stays high
    curReq = "R2 long burst pair";
    sendBurst(20, 1'b0, 1'b0, -1);
    checkCount(20, "R9 count cleared then counted");

    // R4: double-rate burst
    curReq = "R4 dual-rate pair";
    sendBurst(8, 1'b1, 1'b0, -1);
    checkCount(8, "R9 count dual");

    // R6: mode flips mid-burst must be ignored
    curReq = "R6 single kept";
    sendBurst(4, 1'b0, 1'b1, -1);
    checkCount(4, "R6 count single");
    curReq = "R6 dual kept";
    sendBurst(4, 1'b1, 1'b1, -1);
    checkCount(4, "R6 count dual");

    // R8: enable cut mid-pair, partial pair dropped
    curReq = "R8 pair before cut";
    sendBurst(3, 1'b0, 1'b0, 148);
    repeat (5) @(negedge clk);
    checkCount(2, "R8 count after single cut");
    curReq = "R8 dual before cut";
    sendBurst(6, 1'b1, 1'b0, 136);
    repeat (5) @(negedge clk);
    checkCount(3, "R8 count after dual cut");

    // R8: next burst re-aligns from bit 0
    curReq = "R8 realign pair";
    sendBurst(2, 1'b0, 1'b0, -1);
    checkCount(2, "R8 count after realign");

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule